// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM with Matched Read/Write Latency

This block is a synthesizable model of a synchronous pipelined SRAM for use as an on-chip buffer behind a shared data bus. Each enabled rising clock edge accepts one command: a read, a write, a deselect, or a burst continuation. Read data leaves the block, and write data enters it, at the same distance behind the command. A read can therefore follow a write on the very next cycle, and a write can follow a read, with no idle cycles between them.

The data word is split into byte lanes of 9 bits each, with 4 lanes by default. Writes are masked per lane. A two-bit burst counter steps through four consecutive locations in linear or interleaved order. A clock-enable input freezes the whole pipeline. An output-enable input gates the bus drive. A sleep input drops any accesses still in flight while the stored contents are kept.

The storage array has a registered read port. A read can look up the array on the same edge at which an older write commits, and in that case it would see stale data. A one-entry forwarding register closes this gap: it merges that write's data into the read result lane by lane.

Top module: `psram_top`

## Requirements
- R1: While reset is asserted and after it is released, no access is pending and `dq_oe_o` is low until a read reaches the output stage.
- R2: A read whose address is registered on enabled edge k drives the stored word on `dq_o` after enabled edge k+2, with `dq_oe_o` high when `oe_n_i` is low.
- R3: Write data on `dq_i` is sampled at enabled edge k+2 for a write registered at edge k. A low bit `bw_n_i[i]` writes lane i, which is bits 9i+8 down to 9i. A write with every `bw_n_i` bit high changes nothing and never drives the bus.
- R4: Reads and writes alternate on consecutive cycles with no idle cycle. A read always returns the most recent data written to its address, merged per lane, including a write issued on the cycle just before the read.
- R5: With `adv_ld_i` high, the access continues the last loaded burst, and `addr_i`, `we_n_i` and `ce_n_i` are ignored. Step c counts 1, 2, 3, 0 and so on. The two low address bits become base+c modulo 4 when `lin_i` is 1, and base XOR c when `lin_i` is 0. The upper bits keep the base value.
- R6: While `cen_n_i` is high, the clock edge is ignored: no stage advances, outputs hold, and a pending write is not performed on that edge.
- R7: A load with `ce_n_i` high is a deselect. It occupies a pipeline slot, the bus is high-impedance in its output slot, and continuing a deselected burst is also a deselect.
- R8: `dq_oe_o` is high only when a read is in the output stage and `oe_n_i` is low. Raising `oe_n_i` releases the bus in the same cycle.
- R9: While `sleep_i` is high, `dq_oe_o` is low and every access in flight is dropped. Stored contents are preserved across the sleep period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address, used on a load |
| adv_ld_i | input | 1 | 0 starts a new access, 1 continues the burst |
| we_n_i | input | 1 | Active-low write; high means read |
| bw_n_i | input | LANES | Active-low per-lane write selects |
| ce_n_i | input | 1 | Active-low chip select, sampled on a load |
| cen_n_i | input | 1 | Active-low clock enable; high stalls |
| oe_n_i | input | 1 | Active-low output enable, asynchronous gating |
| sleep_i | input | 1 | Active-high low-power state |
| lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| dq_i | input | LANES*LW | Write data bus |
| dq_o | output | LANES*LW | Read data bus |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The hardest case to reach is a read that hits an address while a write to that same address is committing in the array on that very edge. This happens only when the write is issued on the cycle immediately before the read, and it is made harder when a stall separates the two. The stimulus drives write-then-read pairs to one address with complementary lane masks, and inserts stalls between the commands and inside bursts. A long constrained-random stretch then mixes bursts, aborts, deselects and stalls, and every cycle is compared with a queue-based model that has no forwarding path of its own.

// File: rtl/psram_pkg.sv
`timescale 1ns/100ps
package psram_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // Low two address bits for burst step 'step' from starting offset 'base'.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       linear);
    return linear ? (base + step) : (base ^ step);
  endfunction

endpackage

// File: rtl/psram_burst.sv
`timescale 1ns/100ps
module psram_burst
  import psram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [AW-1:0] addr_i,
  input  logic          adv_ld_i,
  input  logic          we_n_i,
  input  logic          ce_n_i,
  input  logic          lin_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] base_q, base_d;
  logic [1:0]    step_q, step_d;
  op_e           op_q, op_d;

  // Next-state: a load takes the external command, a continuation steps.
  always_comb begin
    base_d = base_q;
    step_d = step_q;
    op_d   = op_q;
    if (!adv_ld_i) begin
      base_d = addr_i;
      step_d = 2'd0;
      if (ce_n_i)      op_d = OP_NOP;
      else if (we_n_i) op_d = OP_RD;
      else             op_d = OP_WR;
    end else begin
      step_d = step_q + 2'd1;
    end
    op_o   = op_d;
    addr_o = {base_d[AW-1:2], burst_low(base_d[1:0], step_d, lin_i)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      op_q   <= OP_NOP;
    end else if (clr) begin
      op_q   <= OP_NOP;
    end else if (en) begin
      base_q <= base_d;
      step_q <= step_d;
      op_q   <= op_d;
    end
  end

  // A continuation never changes the access type of the burst (R5, R7).
  assert_cont_keeps_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld_i) |=> (op_q == $past(op_q)));

endmodule

// File: rtl/psram_array.sv
`timescale 1ns/100ps
module psram_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                re_i,
  input  logic [AW-1:0]       raddr_i,
  output logic [LANES*LW-1:0] rdata_o,
  input  logic                we_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [LANES-1:0]    wmask_i,
  input  logic [LANES*LW-1:0] wdata_i
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_q;

    // Registered read returns the contents before a same-edge write.
    always_ff @(posedge clk) begin
      if (we_i && wmask_i[g]) mem[waddr_i] <= wdata_i[g*LW +: LW];
      if (re_i)               rd_q         <= mem[raddr_i];
    end

    assign rdata_o[g*LW +: LW] = rd_q;
  end

endmodule

// File: rtl/psram_fwd.sv
`timescale 1ns/100ps
module psram_fwd #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                clr,
  input  logic                cap_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [LANES-1:0]    wmask_i,
  input  logic [LANES*LW-1:0] wdata_i,
  input  logic [AW-1:0]       raddr_i,
  input  logic [LANES*LW-1:0] rbase_i,
  output logic [LANES*LW-1:0] rdata_o
);

  logic                vld_q, vld_d;
  logic [AW-1:0]       addr_q, addr_d;
  logic [LANES-1:0]    mask_q, mask_d;
  logic [LANES*LW-1:0] data_q, data_d;
  logic                hit;

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    mask_d = mask_q;
    data_d = data_q;
    if (clr) begin
      vld_d = 1'b0;
    end else if (en) begin
      vld_d = cap_i && (|wmask_i);
      if (cap_i) begin
        addr_d = waddr_i;
        mask_d = wmask_i;
        data_d = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      mask_q <= mask_d;
      data_q <= data_d;
    end
  end

  assign hit = vld_q && (addr_q == raddr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rdata_o[g*LW +: LW] = (hit && mask_q[g]) ? data_q[g*LW +: LW]
                                                    : rbase_i[g*LW +: LW];
  end

  // The forwarded write is only valid for the edge right after it commits (R4).
  assert_fwd_one_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cap_i) |=> !vld_q);

endmodule

// File: rtl/psram_top.sv
`timescale 1ns/100ps
module psram_top
  import psram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr_i,
  input  logic                adv_ld_i,
  input  logic                we_n_i,
  input  logic [LANES-1:0]    bw_n_i,
  input  logic                ce_n_i,
  input  logic                cen_n_i,
  input  logic                oe_n_i,
  input  logic                sleep_i,
  input  logic                lin_i,
  input  logic [LANES*LW-1:0] dq_i,
  output logic [LANES*LW-1:0] dq_o,
  output logic                dq_oe_o
);

  localparam int DW = LANES * LW;

  logic          en;
  op_e           cur_op;
  logic [AW-1:0] cur_addr;

  op_e            s1_op_q, s1_op_d, s2_op_q, s2_op_d;
  logic [AW-1:0]  s1_addr_q, s1_addr_d, s2_addr_q, s2_addr_d;
  logic [LANES-1:0] s1_mask_q, s1_mask_d, s2_mask_q, s2_mask_d;

  logic          arr_re, arr_we;
  logic [DW-1:0] arr_rdata, merged;
  logic          out_vld_q, out_vld_d;
  logic [DW-1:0] out_q, out_d;

  assign en = !cen_n_i && !sleep_i;

  psram_burst #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .clr      (sleep_i),
    .addr_i   (addr_i),
    .adv_ld_i (adv_ld_i),
    .we_n_i   (we_n_i),
    .ce_n_i   (ce_n_i),
    .lin_i    (lin_i),
    .op_o     (cur_op),
    .addr_o   (cur_addr)
  );

  // Command pipeline: stage 1 holds the registered command, stage 2 the
  // command whose data moves on the bus at the next enabled edge.
  always_comb begin
    s1_op_d   = s1_op_q;
    s1_addr_d = s1_addr_q;
    s1_mask_d = s1_mask_q;
    s2_op_d   = s2_op_q;
    s2_addr_d = s2_addr_q;
    s2_mask_d = s2_mask_q;
    if (sleep_i) begin
      s1_op_d = OP_NOP;
      s2_op_d = OP_NOP;
    end else if (en) begin
      s1_op_d   = cur_op;
      s1_addr_d = cur_addr;
      s1_mask_d = ~bw_n_i;
      s2_op_d   = s1_op_q;
      s2_addr_d = s1_addr_q;
      s2_mask_d = s1_mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= OP_NOP;
      s1_addr_q <= '0;
      s1_mask_q <= '0;
      s2_op_q   <= OP_NOP;
      s2_addr_q <= '0;
      s2_mask_q <= '0;
    end else begin
      s1_op_q   <= s1_op_d;
      s1_addr_q <= s1_addr_d;
      s1_mask_q <= s1_mask_d;
      s2_op_q   <= s2_op_d;
      s2_addr_q <= s2_addr_d;
      s2_mask_q <= s2_mask_d;
    end
  end

  assign arr_re = en && (s1_op_q == OP_RD);
  assign arr_we = en && (s2_op_q == OP_WR);

  psram_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk     (clk),
    .re_i    (arr_re),
    .raddr_i (s1_addr_q),
    .rdata_o (arr_rdata),
    .we_i    (arr_we),
    .waddr_i (s2_addr_q),
    .wmask_i (s2_mask_q),
    .wdata_i (dq_i)
  );

  psram_fwd #(.AW(AW), .LANES(LANES), .LW(LW)) u_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .clr     (sleep_i),
    .cap_i   (s2_op_q == OP_WR),
    .waddr_i (s2_addr_q),
    .wmask_i (s2_mask_q),
    .wdata_i (dq_i),
    .raddr_i (s2_addr_q),
    .rbase_i (arr_rdata),
    .rdata_o (merged)
  );

  // Output stage
  always_comb begin
    out_vld_d = out_vld_q;
    out_d     = out_q;
    if (sleep_i) begin
      out_vld_d = 1'b0;
    end else if (en) begin
      out_vld_d = (s2_op_q == OP_RD);
      if (s2_op_q == OP_RD) out_d = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else begin
      out_vld_q <= out_vld_d;
      out_q     <= out_d;
    end
  end

  assign dq_o    = out_q;
  assign dq_oe_o = out_vld_q && !oe_n_i && !sleep_i;

  assert_read_reaches_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op_q == OP_RD) |=> out_vld_q);

  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cen_n_i && !sleep_i) |=> ($stable(out_q) && $stable(out_vld_q) &&
                               $stable(s1_op_q) && $stable(s2_op_q)));

  assert_deselect_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld_i && ce_n_i) |=> (s1_op_q == OP_NOP));

  assert_idle_tristate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s2_op_q != OP_RD) |=> !dq_oe_o);

  assert_sleep_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (!out_vld_q && s1_op_q == OP_NOP && s2_op_q == OP_NOP));

endmodule

// File: tb/test_psram_top.sv
`timescale 1ns/100ps
module test_psram_top;

  logic        clk;
  logic        rst_n;
  logic [5:0]  addr;
  logic        adv;
  logic        we_n;
  logic [3:0]  bw_n;
  logic        ce_n;
  logic        cen_n;
  logic        oe_n;
  logic        slp;
  logic        lin;
  logic [35:0] dq_i;
  logic [35:0] dq_o;
  logic        dq_oe;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    cmp_on = 1'b0;

  psram_top i_psram_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (addr),
    .adv_ld_i (adv),
    .we_n_i   (we_n),
    .bw_n_i   (bw_n),
    .ce_n_i   (ce_n),
    .cen_n_i  (cen_n),
    .oe_n_i   (oe_n),
    .sleep_i  (slp),
    .lin_i    (lin),
    .dq_i     (dq_i),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model (ideal memory, queue pipeline) -------
  logic [35:0] mm [64];
  int          q_op[$];
  int          q_ad[$];
  logic [3:0]  q_bw[$];
  int          b_base, b_step, b_op;
  bit          exp_v;
  logic [35:0] exp_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_op.delete(); q_ad.delete(); q_bw.delete();
      b_base = 0; b_step = 0; b_op = 0; exp_v = 1'b0;
    end else if (slp) begin
      q_op.delete(); q_ad.delete(); q_bw.delete();
      b_op = 0; exp_v = 1'b0;
    end else if (!cen_n) begin
      int a;
      int pop_op;
      int pop_ad;
      logic [3:0] pop_bw;
      if (!adv) begin
        b_base = addr; b_step = 0;
        b_op = ce_n ? 0 : (we_n ? 1 : 2);
        a = addr;
      end else begin
        b_step = (b_step + 1) % 4;
        a = (b_base / 4) * 4 + (lin ? ((b_base % 4) + b_step) % 4
                                    : ((b_base % 4) ^ b_step));
      end
      q_op.push_back(b_op); q_ad.push_back(a); q_bw.push_back(bw_n);
      exp_v = 1'b0;
      if (q_op.size() > 2) begin
        pop_op = q_op.pop_front();
        pop_ad = q_ad.pop_front();
        pop_bw = q_bw.pop_front();
        if (pop_op == 2) begin
          for (int l = 0; l < 4; l++)
            if (!pop_bw[l]) mm[pop_ad][l*9 +: 9] = dq_i[l*9 +: 9];
        end else if (pop_op == 1) begin
          exp_v = 1'b1;
          exp_d = mm[pop_ad];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare on every cycle, 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      bit eoe;
      eoe = exp_v && !oe_n && !slp;
      chk(dq_oe == eoe, "bus drive", {35'd0, dq_oe}, {35'd0, eoe});
      if (eoe && dq_oe) chk(dq_o == exp_d, "read data", dq_o, exp_d);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input int a, input bit ad, input bit wn, input logic [3:0] bw,
                       input bit cs_n, input bit ce_hold, input bit oen, input bit sl);
    @(negedge clk);
    addr  = 6'(a);
    adv   = ad;
    we_n  = wn;
    bw_n  = bw;
    ce_n  = cs_n;
    cen_n = ce_hold;
    oe_n  = oen;
    slp   = sl;
    dq_i  = {4'($urandom()), 32'($urandom())};
  endtask

  task automatic wr(input int a, input logic [3:0] bw); drive(a, 0, 0, bw, 0, 0, 0, 0); endtask
  task automatic rd(input int a);                        drive(a, 0, 1, 4'hF, 0, 0, 0, 0); endtask
  task automatic cont(input logic [3:0] bw);             drive($urandom() % 64, 1, $urandom() % 2, bw, $urandom() % 2, 0, 0, 0); endtask
  task automatic desel();                                drive(0, 0, 1, 4'hF, 1, 0, 0, 0); endtask
  task automatic stall();                                drive($urandom() % 64, $urandom() % 2, 0, 4'h0, 0, 1, 0, 0); endtask
  task automatic snooze();                               drive(0, 0, 0, 4'h0, 0, 0, 0, 1); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) desel(); endtask

  // Watchdog: counts as a failed check and still reports.
  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr = '0; adv = 1'b0; we_n = 1'b1; bw_n = 4'hF; ce_n = 1'b1;
    cen_n = 1'b0; oe_n = 1'b0; slp = 1'b0; lin = 1'b1; dq_i = '0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk(dq_oe == 1'b0, "drive in reset", {35'd0, dq_oe}, 36'd0);
    rst_n = 1'b1;
    idle(3);
    chk(dq_oe == 1'b0, "drive after reset", {35'd0, dq_oe}, 36'd0);
    cmp_on = 1'b1;

    // R3: fill every word with all lanes
    tag = "R3";
    for (int a = 0; a < 64; a++) wr(a, 4'h0);
    idle(3);

    // R2: plain reads with latency two
    tag = "R2";
    for (int a = 0; a < 16; a++) rd(a);
    idle(3);

    // R3: partial lanes and a write abort
    tag = "R3";
    wr(5, 4'b1010); wr(6, 4'b1111); wr(7, 4'b0110); idle(2);
    rd(5); rd(6); rd(7); idle(3);

    // R4: back-to-back write/read to the same address
    tag = "R4";
    wr(9, 4'b0011); rd(9); wr(9, 4'b1100); rd(9); rd(9);
    for (int i = 0; i < 8; i++) begin
      wr(10 + (i % 2), 4'($urandom())); rd(10 + (i % 2));
    end
    wr(12, 4'b0101); wr(12, 4'b1010); rd(12); rd(12);
    idle(3);

    // R5: bursts in both orders with offset starts and wrap-around
    tag = "R5";
    lin = 1'b1;
    rd(13); cont(4'hF); cont(4'hF); cont(4'hF); cont(4'hF); cont(4'hF);
    wr(22, 4'h0); cont(4'b0001); cont(4'h0); cont(4'b1000);
    idle(2); rd(20); rd(21); rd(22); rd(23); idle(2);
    lin = 1'b0;
    rd(14); cont(4'hF); cont(4'hF); cont(4'hF);
    wr(25, 4'h0); cont(4'h0); cont(4'b0110); cont(4'h0);
    idle(2); rd(24); cont(4'hF); cont(4'hF); cont(4'hF); idle(3);

    // R6: stalls in the middle of write and read traffic
    tag = "R6";
    lin = 1'b1;
    wr(30, 4'h0); stall(); stall(); rd(30); stall(); wr(30, 4'b1001);
    stall(); rd(30); stall(); stall(); cont(4'hF); stall(); idle(3);

    // R7: deselect and continuation of a deselect
    tag = "R7";
    rd(31); desel(); cont(4'hF); cont(4'h0); rd(32); idle(3);

    // R8: output enable released while reads are in the output stage
    tag = "R8";
    rd(1); rd(2); drive(3, 0, 1, 4'hF, 0, 0, 1, 0); drive(0, 0, 1, 4'hF, 1, 0, 1, 0);
    drive(0, 0, 1, 4'hF, 1, 0, 0, 0); idle(2);

    // R9: sleep with accesses in flight, contents preserved
    tag = "R9";
    wr(40, 4'h0); wr(41, 4'h0); idle(2);
    rd(40); wr(41, 4'h0); snooze(); snooze(); snooze();
    rd(40); rd(41); rd(42); snooze(); idle(4);

    // Mixed traffic
    tag = "R4";
    for (int i = 0; i < 800; i++) begin
      int r;
      r = $urandom() % 100;
      lin = (i / 100) % 2 == 0;
      if (r < 30)      wr($urandom() % 8, 4'($urandom()));
      else if (r < 60) rd($urandom() % 8);
      else if (r < 75) cont(4'($urandom()));
      else if (r < 83) stall();
      else if (r < 90) desel();
      else if (r < 96) drive($urandom() % 8, 0, 1, 4'hF, 0, 0, 1, 0);
      else             snooze();
    end
    idle(4);

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule